// File: doc/BRIEF.md
# Collision-Vector Pipeline Issue Controller

This controller decides, cycle by cycle, whether a new operation may be launched into a nonlinear pipeline whose stages are reused at several points in time. Software or a neighbouring block programs a forbidden-latency mask. The controller then keeps an M-bit state word that shows which of the next M cycles would put two operations into one stage. The state shifts right by one bit every clock. When an issue happens, the shifted word is also ORed with the mask. An issue is granted only when bit 0 of the current state is clear.

Issue requests use a valid/ready handshake. The requester raises `iss_valid` and holds it, with the operation unchanged, until it sees `iss_ready` high at a clock edge. That edge is the issue. `iss_ready` is never high without `iss_valid`, so a requester that is not asking sees no grant. The controller holds a request back for as long as the stage occupancy requires; there is no limit on how long. The controller has two policies. In greedy mode, a held request issues at the first permissible latency. In fixed mode, it issues only at one chosen latency, or once the pipeline has drained.

A counter of cycles since the last issue saturates at M+1. It is available as status. It also marks the idle condition, and the mask can be reloaded only while the controller is idle.

Top module: `cvic_top`

## Requirements
- R1: After reset `state_o` is 0, `since_o` is M+1, the mask is 0, and a request is granted in the first cycle.
- R2: Mask bit i-1 (bit 0 = latency 1) set forbids issuing i cycles after the previous issue. With mask 7'b1011010 from a drained pipeline, latencies 1, 3, 6 and 8 are granted and latencies 2, 4, 5 and 7 are refused.
- R3: `iss_ready` is high only when `iss_valid` is high and bit 0 of `state_o` is 0.
- R4: Every clock, `state_o` shifts right by one; on an issue edge the shifted value is ORed with the mask.
- R5: An issue made more than M cycles after the previous one (or from reset) leaves `state_o` equal to the mask.
- R6: `since_o` is 1 in the cycle after an issue, increments each cycle, and holds at M+1.
- R7: `cfg_we` loads `cfg_vec` into the mask only when `since_o` equals M+1; otherwise it is ignored.
- R8: With `greedy`=1 and the request held, issues occur at every first permissible latency; with mask 7'b1011010 from idle, grants fall at offsets 0, 1, 9 and 10.
- R9: With `greedy`=0, a grant also needs `since_o` equal to `lat_sel` or equal to M+1. With mask 7'b1011010: `lat_sel`=3 gives grants at offsets 0, 3, 6, 9; `lat_sel`=2 gives offsets 0 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mask load strobe, honoured only when idle |
| cfg_vec | input | M | Forbidden-latency mask, bit 0 = latency 1 |
| greedy | input | 1 | 1 = greedy policy, 0 = fixed latency |
| lat_sel | input | CW | Chosen latency for fixed mode |
| iss_valid | input | 1 | Issue request, held until granted |
| iss_ready | output | 1 | Grant; an edge with both high is an issue |
| state_o | output | M | Current collision state |
| since_o | output | CW | Cycles since last issue, saturating at M+1 |

## Verification
The collision assertion compares the latency of each issue with the mask. It is only meaningful if the mask stays fixed while earlier operations are still in flight. The controller enforces this by accepting mask writes only when idle. The bench also writes the mask only after waiting M+2 quiet cycles. The bench drives inputs on the falling edge and keeps `iss_valid` steady through each rising edge. The handshake is therefore always sampled on settled values.

// File: rtl/cvic_pkg.sv
package cvic_pkg;
  typedef enum logic {
    MODE_FIXED  = 1'b0,
    MODE_GREEDY = 1'b1
  } iss_mode_e;
endpackage

// File: rtl/cvic_state.sv
module cvic_state #(
  parameter int M = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic         idle,
  input  logic         cfg_we,
  input  logic [M-1:0] cfg_vec,
  output logic [M-1:0] st_o,
  output logic [M-1:0] cv_o
);
  logic [M-1:0] st_q, cv_q, st_shift;

  assign st_shift = st_q >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= '0;
      cv_q <= '0;
    end else begin
      st_q <= fire ? (st_shift | cv_q) : st_shift;
      if (cfg_we && idle) cv_q <= cfg_vec;
    end
  end

  assign st_o = st_q;
  assign cv_o = cv_q;

  // R4: an issue edge never clears a mask bit in the next state
  p_issue_covers_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> ((st_q & $past(cv_q)) == $past(cv_q)));
endmodule

// File: rtl/cvic_latcnt.sv
module cvic_latcnt #(
  parameter int M  = 7,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  output logic [CW-1:0] since_o,
  output logic          idle_o
);
  localparam logic [CW-1:0] SAT = CW'(M + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= SAT;
    else if (fire)         cnt_q <= CW'(1);
    else if (cnt_q != SAT) cnt_q <= cnt_q + CW'(1);
  end

  assign since_o = cnt_q;
  assign idle_o  = (cnt_q == SAT);

  p_cnt_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= CW'(1)) && (cnt_q <= SAT));
  p_cnt_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == CW'(1)));
endmodule

// File: rtl/cvic_gate.sv
module cvic_gate
  import cvic_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iss_valid,
  input  iss_mode_e     mode,
  input  logic [CW-1:0] lat_sel,
  input  logic [CW-1:0] since,
  input  logic          idle,
  input  logic          blocked,
  output logic          iss_ready
);
  logic timing_ok;

  always_comb begin
    unique case (mode)
      MODE_GREEDY: timing_ok = 1'b1;
      MODE_FIXED:  timing_ok = idle || (since == lat_sel);
      default:     timing_ok = 1'b0;
    endcase
  end

  assign iss_ready = iss_valid && !blocked && timing_ok;

  // R3: no grant without a request
  p_grant_has_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_ready |-> iss_valid);
endmodule

// File: rtl/cvic_top.sv
module cvic_top
  import cvic_pkg::*;
#(
  parameter int M = 7,
  localparam int CW = $clog2(M + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [M-1:0]  cfg_vec,
  input  logic          greedy,
  input  logic [CW-1:0] lat_sel,
  input  logic          iss_valid,
  output logic          iss_ready,
  output logic [M-1:0]  state_o,
  output logic [CW-1:0] since_o
);
  localparam logic [CW-1:0] SAT = CW'(M + 1);

  logic          fire, idle;
  logic [M-1:0]  st, cv, cv_at_lat;
  logic [CW-1:0] since;
  iss_mode_e     mode;

  assign mode = greedy ? MODE_GREEDY : MODE_FIXED;
  assign fire = iss_valid && iss_ready;

  cvic_state #(.M(M)) u_state (
    .clk(clk), .rst_n(rst_n), .fire(fire), .idle(idle),
    .cfg_we(cfg_we), .cfg_vec(cfg_vec), .st_o(st), .cv_o(cv)
  );

  cvic_latcnt #(.M(M), .CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .fire(fire), .since_o(since), .idle_o(idle)
  );

  cvic_gate #(.CW(CW)) u_gate (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .mode(mode),
    .lat_sel(lat_sel), .since(since), .idle(idle), .blocked(st[0]),
    .iss_ready(iss_ready)
  );

  assign state_o = st;
  assign since_o = since;

  // mask bit for the latency of the issue being made now
  assign cv_at_lat = cv >> (since - CW'(1));

  // R2: an issue never uses a latency the mask forbids
  p_no_collision_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && since <= CW'(M)) |-> !cv_at_lat[0]);
  // R5: once the counter has saturated the pipeline holds no reservations
  p_drained_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (since == SAT) |-> (st == '0));
endmodule

// File: tb/sim_cvic_top.sv
`timescale 1ns/100ps
module sim_cvic_top;
  localparam int M = 7;
  localparam int CW = 4;
  localparam logic [M-1:0] CVA = 7'b1011010;
  localparam logic [M-1:0] CVB = 7'b0000101;
  // {latency[3:0], expected grant} from a drained pipeline, mask CVA
  localparam logic [4:0] TBL [8] = '{
    {4'd1, 1'b1}, {4'd2, 1'b0}, {4'd3, 1'b1}, {4'd4, 1'b0},
    {4'd5, 1'b0}, {4'd6, 1'b1}, {4'd7, 1'b0}, {4'd8, 1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, greedy = 1'b1, iss_valid = 1'b0;
  logic [M-1:0] cfg_vec = '0;
  logic [CW-1:0] lat_sel = '0;
  logic iss_ready;
  logic [M-1:0] state_o;
  logic [CW-1:0] since_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cvic_top #(.M(M)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_vec(cfg_vec),
    .greedy(greedy), .lat_sel(lat_sel), .iss_valid(iss_valid),
    .iss_ready(iss_ready), .state_o(state_o), .since_o(since_o));

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic drain();
    iss_valid = 1'b0;
    repeat (M + 2) @(negedge clk);
  endtask

  task automatic load(input logic [M-1:0] v);
    cfg_we = 1'b1; cfg_vec = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // hold a request for 12 cycles from idle and collect the grant offsets
  task automatic held(output logic [11:0] mask);
    mask = '0;
    iss_valid = 1'b1;
    for (int k = 0; k < 12; k++) begin
      #1 mask[k] = iss_ready;
      @(negedge clk);
    end
    iss_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] gm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 state", 32'(state_o), 32'h0);
    chk("R1 since", 32'(since_o), 32'(M + 1));
    iss_valid = 1'b1;
    #1 chk("R1 first grant", 32'(iss_ready), 32'h1);
    iss_valid = 1'b0;
    @(negedge clk);
    load(CVA);
    drain();

    // R2 / R5 / R6: latency table, greedy mode
    foreach (TBL[i]) begin
      int p;
      p = int'(TBL[i][4:1]);
      iss_valid = 1'b1;
      #1 chk("R3 idle grant", 32'(iss_ready), 32'h1);
      @(negedge clk);
      iss_valid = 1'b0;
      chk("R5 state after issue", 32'(state_o), 32'(CVA));
      chk("R6 since after issue", 32'(since_o), 32'h1);
      repeat (p - 1) @(negedge clk);
      iss_valid = 1'b1;
      #1 chk($sformatf("R2 latency %0d", p), 32'(iss_ready), 32'(TBL[i][0]));
      chk("R6 since at latency", 32'(since_o), 32'(p));
      @(negedge clk);
      drain();
    end

    // R3: no request, no grant
    #1 chk("R3 idle no req", 32'(iss_ready), 32'h0);

    // R8: greedy cycle with a held request
    greedy = 1'b1;
    held(gm);
    chk("R8 greedy offsets", 32'(gm), 32'h603);
    drain();

    // R9: fixed latency 3 and 2
    greedy = 1'b0; lat_sel = 4'd3;
    held(gm);
    chk("R9 fixed 3 offsets", 32'(gm), 32'h249);
    drain();
    lat_sel = 4'd2;
    held(gm);
    chk("R9 fixed 2 offsets", 32'(gm), 32'h101);
    drain();
    greedy = 1'b1;

    // R4: shift every cycle without issue
    iss_valid = 1'b1;
    @(negedge clk);
    iss_valid = 1'b0;
    @(negedge clk);
    chk("R4 one shift", 32'(state_o), 32'(CVA >> 1));
    @(negedge clk);
    chk("R4 two shifts", 32'(state_o), 32'(CVA >> 2));
    drain();

    // R7: write while busy is ignored
    iss_valid = 1'b1;
    @(negedge clk);
    iss_valid = 1'b0;
    load(CVB);
    drain();
    iss_valid = 1'b1;
    @(negedge clk);
    iss_valid = 1'b0;
    chk("R7 busy write ignored", 32'(state_o), 32'(CVA));
    drain();
    // R7: write while idle is taken
    load(CVB);
    drain();
    iss_valid = 1'b1;
    @(negedge clk);
    chk("R7 idle write taken", 32'(state_o), 32'(CVB));
    #1 chk("R2 new mask latency 1", 32'(iss_ready), 32'h0);
    iss_valid = 1'b0;
    @(negedge clk);

    // R1: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 reset state", 32'(state_o), 32'h0);
    chk("R1 reset since", 32'(since_o), 32'(M + 1));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule